// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O data port. A 1 KB slice of the register space reaches one data register. The offset itself, rather than the bus data, decides which pins an access touches. Software can set or clear a single pin, or any subset of pins, with one store and without first reading the register. A second register picks each pin's direction.

External input levels go through a two-flop synchronizer before they land in the data register. Output pins hold what the bus last wrote to them. Every pin that is not an output presents a high level on its output side. A one-cycle strobe marks every pin whose driven value changes. The current data and direction values are exported so that a neighbouring interrupt unit can watch the pins.

Top module: `gpio_amp_port`

## Requirements
- R1: Every byte offset below 0x400 selects the data register. Offset bits [9:2] form an eight-bit pin mask, with offset bit 2+i selecting pin i.
- R2: A read of the data window returns the data register ANDed with the offset mask, so masked-off bits read 0. `rd_data` carries the result from the cycle after `rd_en` and keeps it until the next read.
- R3: A write to the data window updates only the bits set in both the offset mask and the direction register. The bus has no effect on input pins.
- R4: The direction register sits at offset 0x400 and can be written and read there. A 1 makes the pin an output, and `pin_oe` and `dir_o` show its value.
- R5: The driven value is `pin_out = (data & dir) | ~dir`, so every input pin presents 1.
- R6: The data bit of an input pin takes the external level three clock edges after the level is applied: two synchronizer stages plus the register.
- R7: The data bit of an output pin does not depend on the external pin level.
- R8: After reset the data and direction registers are 0, `pin_out` is all ones, `pin_oe` is 0, `rd_data` is 0 and no change strobe is active.
- R9: `out_chg[i]` is high for exactly one cycle, the first cycle in which `pin_out[i]` shows a new value.
- R10: A read of any offset other than the data window or 0x400 returns 0. A write to any such offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| offset | input | 12 | Byte offset of the access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Output enable per pin |
| out_chg | output | 8 | One-cycle strobe per changed driven value |
| data_o | output | 8 | Current data register, for an interrupt unit |
| dir_o | output | 8 | Current direction register |

## Verification
A register write shows up on `data_o`, `dir_o`, `pin_out` and `out_chg` one edge after the write, and read data appears on `rd_data` one edge after `rd_en`. An input level reaches `data_o` three edges after it is applied. The bench drives every input at the falling edge and keeps a cycle-accurate reference model that advances once per rising edge, including a two-stage model of the input path. It compares every output at the following falling edge, so each result is checked in the very cycle it falls due.

// File: rtl/gpio_amp_pkg.sv
package gpio_amp_pkg;

    // Kind of register reached by a bus offset
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/gpio_amp_sync.sv
module gpio_amp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_amp_regs.sv
module gpio_amp_regs
    import gpio_amp_pkg::*;
#(
    parameter int                WIDTH      = 8,
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] offset,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  data_q_o,
    output logic [WIDTH-1:0]  dir_q_o,
    output logic [WIDTH-1:0]  rd_data
);

    localparam int                MASK_LO = 2;
    localparam int                MASK_HI = WIDTH + MASK_LO - 1;
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(1) << (WIDTH + MASK_LO);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t            st_d, st_q;
    acc_kind_e        acc;
    logic [WIDTH-1:0] mask;
    logic             wr_data_hit;
    logic             rd_data_hit;

    // Offset decode: window first, then the direction slot
    always_comb begin
        if (offset < WIN_END)          acc = ACC_DATA;
        else if (offset == DIR_OFFSET) acc = ACC_DIR;
        else                           acc = ACC_NONE;
    end

    assign mask        = offset[MASK_HI:MASK_LO];
    assign wr_data_hit = wr_en && (acc == ACC_DATA);
    assign rd_data_hit = rd_en && (acc == ACC_DATA);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            if (!st_q.dir[i]) begin
                st_d.data[i] = pin_sync[i];
            end else if (wr_data_hit && mask[i]) begin
                st_d.data[i] = wr_data[i];
            end
        end
        if (wr_en && (acc == ACC_DIR)) begin
            st_d.dir = wr_data;
        end
        if (rd_en) begin
            unique case (acc)
                ACC_DATA: st_d.rdata = st_q.data & mask;
                ACC_DIR:  st_d.rdata = st_q.dir;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q_o = st_q.data;
    assign dir_q_o  = st_q.dir;
    assign rd_data  = st_q.rdata;

    AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data_hit) |-> ((rd_data & ~$past(mask)) == '0)); // R2

    AST_WRITE_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q.data ^ $past(st_q.data)) & $past(st_q.dir)
          & ~($past(wr_data_hit) ? $past(mask) : '0)) == '0)); // R3

    AST_INPUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q.data ^ $past(pin_sync)) & ~$past(st_q.dir)) == '0)); // R6

    AST_OUTPUT_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (((st_q.data ^ $past(st_q.data)) & $past(st_q.dir)) == '0)); // R7

endmodule

// File: rtl/gpio_amp_outdrv.sv
module gpio_amp_outdrv #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] out_chg
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } drv_t;

    drv_t             st_d, st_q;
    logic [WIDTH-1:0] drive_val;

    // Per pin: output pins drive their data bit, input pins present 1
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        assign drive_val[g] = dir_q[g] ? data_q[g] : 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = drive_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: '1};
        else        st_q <= st_d;
    end

    assign pin_out = drive_val;
    assign pin_oe  = dir_q;
    assign out_chg = drive_val ^ st_q.prev;

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_chg & ~(pin_out ^ $past(pin_out))) == '0)); // R9

    AST_INPUT_PRESENTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(~dir_q) & ~pin_out) == '0) || ($past(dir_q) != dir_q)); // R5

endmodule

// File: rtl/gpio_amp_port.sv
module gpio_amp_port
    import gpio_amp_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] offset,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  out_chg,
    output logic [WIDTH-1:0]  data_o,
    output logic [WIDTH-1:0]  dir_o
);

    localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << (WIDTH + 2);

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;

    gpio_amp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio_amp_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFF)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .offset  (offset),
        .wr_data (wr_data),
        .pin_sync(pin_sync),
        .data_q_o(data_q),
        .dir_q_o (dir_q),
        .rd_data (rd_data)
    );

    gpio_amp_outdrv #(.WIDTH(WIDTH)) u_outdrv (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pin_out(pin_out),
        .pin_oe (pin_oe),
        .out_chg(out_chg)
    );

    assign data_o = data_q;
    assign dir_o  = dir_q;

    AST_OE_MATCHES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (offset == DIR_OFF)) |-> (pin_oe == $past(wr_data))); // R4

endmodule

// File: tb/gpio_amp_port_tb_top.sv
module gpio_amp_port_tb_top;

    localparam int W  = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [AW-1:0] offset;
    logic [W-1:0]  wr_data, rd_data, pin_in, pin_out, pin_oe, out_chg, data_o, dir_o;

    always #10 clk = ~clk;

    gpio_amp_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .offset(offset),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .out_chg(out_chg), .data_o(data_o), .dir_o(dir_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state
    logic [W-1:0] m_data, m_dir, m_rd, m_prev, m_s1, m_s2;

    function automatic logic [W-1:0] drive_of(logic [W-1:0] d, logic [W-1:0] dr);
        return (d & dr) | ~dr;
    endfunction

    function automatic logic in_win(logic [AW-1:0] o);
        return o < 12'h400;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One rising edge with the reference advanced, then checks at the falling edge
    task automatic tick();
        logic [W-1:0] nd, mask;
        mask = offset[9:2];
        nd = m_data;
        for (int i = 0; i < W; i++) begin
            if (!m_dir[i]) nd[i] = m_s2[i];
            else if (wr_en && in_win(offset) && mask[i]) nd[i] = wr_data[i];
        end
        if (rd_en) begin
            if (in_win(offset))          m_rd = m_data & mask;
            else if (offset == 12'h400) m_rd = m_dir;
            else                         m_rd = '0;
        end
        m_prev = drive_of(m_data, m_dir);
        if (wr_en && offset == 12'h400) m_dir = wr_data;
        m_data = nd;
        m_s2 = m_s1;
        m_s1 = pin_in;
        @(posedge clk);
        @(negedge clk);
        chk("R3/R6/R7 data_o", data_o, m_data);
        chk("R4 dir_o", dir_o, m_dir);
        chk("R4 pin_oe", pin_oe, m_dir);
        chk("R5 pin_out", pin_out, drive_of(m_data, m_dir));
        chk("R9 out_chg", out_chg, drive_of(m_data, m_dir) ^ m_prev);
        chk("R2/R1/R10 rd_data", rd_data, m_rd);
    endtask

    task automatic op(logic w, logic r, logic [AW-1:0] o, logic [W-1:0] d);
        wr_en = w; rd_en = r; offset = o; wr_data = d;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; offset = '0; wr_data = '0; pin_in = '0;
        m_data = '0; m_dir = '0; m_rd = '0; m_prev = '1; m_s1 = '0; m_s2 = '0;
        repeat (3) @(negedge clk);
        // R8: reset values
        chk("R8 data_o", data_o, 8'h00);
        chk("R8 dir_o", dir_o, 8'h00);
        chk("R8 pin_out", pin_out, 8'hFF);
        chk("R8 pin_oe", pin_oe, 8'h00);
        chk("R8 rd_data", rd_data, 8'h00);
        chk("R8 out_chg", out_chg, 8'h00);
        rst_n = 1'b1;

        // R4: upper nibble becomes outputs
        op(1, 0, 12'h400, 8'hF0);
        // R3: full mask write, input bits untouched
        op(1, 0, 12'h3FC, 8'hFF);
        chk("R3 data_o", data_o, 8'hF0);
        // R1: mask 0x30 clears pins 4 and 5 only; R9 strobes them
        op(1, 0, 12'h0C0, 8'h00);
        chk("R1 data_o", data_o, 8'hC0);
        chk("R9 out_chg", out_chg, 8'h30);
        op(0, 0, 12'h000, 8'h00);
        chk("R9 strobe cleared", out_chg, 8'h00);
        // R2: mask 0x81
        op(0, 1, 12'h204, 8'h00);
        chk("R2 rd_data", rd_data, 8'h80);
        // R6/R7: all pins high, only inputs follow
        pin_in = 8'hFF;
        op(0, 0, 12'h000, 8'h00);
        op(0, 0, 12'h000, 8'h00);
        chk("R6 not yet through", data_o, 8'hC0);
        op(0, 0, 12'h000, 8'h00);
        chk("R6/R7 data_o", data_o, 8'hCF);
        // R10: unused offset
        op(1, 0, 12'h404, 8'hFF);
        op(0, 1, 12'h404, 8'h00);
        chk("R10 rd_data", rd_data, 8'h00);
        chk("R10 dir_o", dir_o, 8'hF0);
        op(0, 1, 12'h400, 8'h00);
        chk("R4 rd_data", rd_data, 8'hF0);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [AW-1:0] o;
            sel = $urandom_range(0, 9);
            if (sel < 6)      o = {2'b00, 8'($urandom), 2'b00};
            else if (sel < 8) o = 12'h400;
            else              o = {10'($urandom_range(257, 1023)), 2'b00};
            if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
            op(1'($urandom), 1'($urandom), o, 8'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule